// File: doc/BRIEF.md
# Protected Message Framer

This block turns a run of parallel bytes into one protected serial message and back again. In transmit it asks for each byte with a one-cycle data pulse and takes the byte from an 8-bit input. It then shifts the message out least significant bit first. The message can start with a start bit, and it can carry a self-protected size byte. After the data bytes comes a check field of 7 or 15 bits. In receive it rebuilds the bytes from the serial input and shows each one on the output bus with a data pulse. It verifies the size byte and compares the received check field with an expected value. Every error class it sees is latched into a sticky status register. That register drives an error output and can be read on the bus in a dedicated operating mode.

Bit timing and the check arithmetic are outside the block. An external sampler supplies a bit strobe, the sampled bit and a flag that marks a distorted bit. An external calculator supplies the check value to send and the check value to expect. The message length is either fixed by a 2-bit code or carried in the size byte. The operating mode, length code, check width and line mode must stay constant while a message is in progress. Bit strobes must be at least two clock cycles apart.

Top module: `msg_framer`

## Requirements
- R1: After reset, busy, data_pulse and err are 0, ser_out is 1 and the status bits are 0.
- R2: len_code 01, 10 and 11 select a fixed length of 2, 4 and 6 data bytes, and no size byte is sent or expected. len_code 00 selects variable length through the size byte.
- R3: In variable-length transmit, the first data pulse takes the count n from tx_byte bits 2:0 and ignores bits 7:3. The block then sends the size byte {p, n, p, n} (bit 7 down to bit 0), where p is the XOR of the three bits of n. n+1 data bytes follow.
- R4: When idle, ser_out is 1. In line mode async_mode=1, a message begins with one 0 start bit; with async_mode=0 there is no start bit. Every byte and the check field go out least significant bit first, each on one bit strobe. One final 1 ends the message.
- R5: After the last data byte, the block sends the low 7 bits of chk_tx (long_chk=0) or all 15 bits (long_chk=1), least significant bit first.
- R6: Each byte transfer is marked by data_pulse high for exactly one cycle. In transmit, tx_byte is captured in that cycle. In receive, the byte is on bus_out in that cycle.
- R7: Transmit: busy is high from the cycle after start until the strobe that sends the final 1. Receive: busy is high from the cycle after the start event until the cycle after the last check-field strobe.
- R8: In receive, a size byte whose upper copy or either parity bit disagrees with its bits 2:0 sets status bit 2. The count is still taken from bits 2:0.
- R9: In receive, a received check field that differs from the matching width of chk_rx sets status bit 1.
- R10: In async receive, rx_bit_bad high on a strobe within a message sets status bit 0. In sync receive it is ignored.
- R11: Status bits stay set until reset. err is high while any status bit is set. In op_sel 00 or 11, bus_out carries the status in bits 2:0 with zeros above, and start does nothing.
- R12: Receive starts on start=1 in sync mode. In async mode it starts on a strobe that samples rx_bit=0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 2 | 00/11 status read, 01 receive, 10 transmit |
| async_mode | input | 1 | 1: start bit and bit check used; 0: start input marks the message |
| len_code | input | 2 | 00 variable length, 01/10/11 fixed 2/4/6 bytes |
| long_chk | input | 1 | Check field width: 0 gives 7 bits, 1 gives 15 bits |
| start | input | 1 | Transmit start, or message sync in sync receive |
| bit_tick | input | 1 | Strobe for one bit period |
| rx_bit | input | 1 | Sampled serial input bit |
| rx_bit_bad | input | 1 | External sampler flags the current bit as distorted |
| tx_byte | input | 8 | Parallel byte for transmit |
| chk_tx | input | 15 | Check value to send |
| chk_rx | input | 15 | Check value expected in receive |
| bus_out | output | 8 | Received byte, or status in status mode |
| data_pulse | output | 1 | One-cycle byte transfer pulse |
| busy | output | 1 | Message in progress |
| err | output | 1 | Any status bit set |
| ser_out | output | 1 | Serial message output |

## Verification
A wrong bit or byte counter shows up on the serial output, or in the number of data pulses, within one byte time. A wrong phase shifts every later field: the check field lands on the wrong strobes and the final 1 comes early or late. A fault in the size-byte decoder either changes the number of bytes delivered or leaves a stale status bit. That bit is visible on bus_out in status mode as soon as the message ends. A status bit that clears by itself can only be seen by reading status again after a later clean message, so the bench does exactly that.

// File: rtl/msg_framer_pkg.sv
package msg_framer_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 3;
    localparam int CHK_W     = 15;
    localparam int CHK_SHORT = 7;
    localparam int BCNT_W    = 4;
    localparam int LEFT_W    = 4;
    localparam int STAT_W    = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SIZE,
        PH_DATA,
        PH_CHK,
        PH_END
    } phase_t;

    typedef enum logic [1:0] {
        OP_STAT = 2'b00,
        OP_RX   = 2'b01,
        OP_TX   = 2'b10,
        OP_RSV  = 2'b11
    } op_t;

    typedef struct packed {
        phase_t              phase;
        logic                txm;
        logic                sof;
        logic [CHK_W-1:0]    sh;
        logic [BCNT_W-1:0]   bcnt;
        logic [LEFT_W-1:0]   left;
        logic                dp;
        logic                ser;
        logic                busy;
        logic [BYTE_W-1:0]   rxd;
    } core_t;
endpackage

// File: rtl/msg_len_decode.sv
module msg_len_decode #(
    parameter int LEFT_W = 4
) (
    input  logic [1:0]        len_code,
    output logic              var_len,
    output logic [LEFT_W-1:0] fixed_cnt
);
    always_comb begin
        var_len   = 1'b0;
        fixed_cnt = '0;
        case (len_code)
            2'b01:   fixed_cnt = LEFT_W'(2);
            2'b10:   fixed_cnt = LEFT_W'(4);
            2'b11:   fixed_cnt = LEFT_W'(6);
            default: var_len   = 1'b1;
        endcase
    end
endmodule

// File: rtl/msg_size_codec.sv
module msg_size_codec #(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0]       cnt_in,
    output logic [2*(CNT_W+1)-1:0] size_out,
    input  logic [2*(CNT_W+1)-1:0] size_in,
    output logic [CNT_W-1:0]       cnt_out,
    output logic                   size_ok
);
    logic             par_tx;
    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] hi_cnt;
    logic             lo_par;
    logic             hi_par;

    always_comb begin
        par_tx   = ^cnt_in;
        size_out = {par_tx, cnt_in, par_tx, cnt_in};
        lo_cnt   = size_in[CNT_W-1:0];
        lo_par   = size_in[CNT_W];
        hi_cnt   = size_in[2*CNT_W:CNT_W+1];
        hi_par   = size_in[2*CNT_W+1];
        cnt_out  = lo_cnt;
        size_ok  = (hi_cnt == lo_cnt) && (lo_par == ^lo_cnt) && (hi_par == ^lo_cnt);
    end
endmodule

// File: rtl/msg_status_reg.sv
module msg_status_reg #(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_bits,
    output logic [STAT_W-1:0] status,
    output logic              err
);
    logic [STAT_W-1:0] status_d, status_q;

    always_comb begin
        status_d = status_q | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    assign status = status_q;
    assign err    = |status_q;

    // R11
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q & $past(status_q)) == $past(status_q));
endmodule

// File: rtl/msg_framer.sv
module msg_framer
    import msg_framer_pkg::*;
#(
    parameter int DATA_W  = BYTE_W,
    parameter int CHKF_W  = CHK_W,
    parameter int CHKF_SH = CHK_SHORT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_sel,
    input  logic              async_mode,
    input  logic [1:0]        len_code,
    input  logic              long_chk,
    input  logic              start,
    input  logic              bit_tick,
    input  logic              rx_bit,
    input  logic              rx_bit_bad,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [CHKF_W-1:0] chk_tx,
    input  logic [CHKF_W-1:0] chk_rx,
    output logic [DATA_W-1:0] bus_out,
    output logic              data_pulse,
    output logic              busy,
    output logic              err,
    output logic              ser_out
);
    localparam logic [CHKF_W-1:0] SHORT_MASK = {{(CHKF_W-CHKF_SH){1'b0}}, {CHKF_SH{1'b1}}};
    localparam logic [BCNT_W-1:0] BYTE_LAST  = BCNT_W'(DATA_W - 1);
    localparam logic [BCNT_W-1:0] LONG_LAST  = BCNT_W'(CHKF_W - 1);
    localparam logic [BCNT_W-1:0] SHORT_LAST = BCNT_W'(CHKF_SH - 1);
    localparam core_t CORE_RST = '{phase: PH_IDLE, txm: 1'b0, sof: 1'b0, sh: '0,
                                   bcnt: '0, left: '0, dp: 1'b0, ser: 1'b1,
                                   busy: 1'b0, rxd: '0};

    core_t core_d, core_q;

    logic              var_len;
    logic [LEFT_W-1:0] fixed_cnt;
    logic [DATA_W-1:0] size_enc;
    logic [DATA_W-1:0] rx_byte;
    logic [CNT_W-1:0]  rx_cnt;
    logic              size_ok;
    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] status;
    logic              is_tx, is_rx;
    logic [CHKF_W-1:0] chk_mask;
    logic [BCNT_W-1:0] chk_last;
    logic [CHKF_W-1:0] chk_full;
    logic [CHKF_W-1:0] chk_got;

    msg_len_decode #(.LEFT_W(LEFT_W)) u_len (
        .len_code (len_code),
        .var_len  (var_len),
        .fixed_cnt(fixed_cnt)
    );

    msg_size_codec #(.CNT_W(CNT_W)) u_size (
        .cnt_in  (tx_byte[CNT_W-1:0]),
        .size_out(size_enc),
        .size_in (rx_byte),
        .cnt_out (rx_cnt),
        .size_ok (size_ok)
    );

    msg_status_reg #(.STAT_W(STAT_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_bits(set_bits),
        .status  (status),
        .err     (err)
    );

    always_comb begin
        is_tx    = (op_sel == OP_TX);
        is_rx    = (op_sel == OP_RX);
        chk_mask = long_chk ? {CHKF_W{1'b1}} : SHORT_MASK;
        chk_last = long_chk ? LONG_LAST : SHORT_LAST;
        rx_byte  = {rx_bit, core_q.sh[DATA_W-1:1]};
        chk_full = {rx_bit, core_q.sh[CHKF_W-1:1]};
        chk_got  = long_chk ? chk_full : (chk_full >> (CHKF_W - CHKF_SH));
    end

    always_comb begin
        core_d   = core_q;
        core_d.dp = 1'b0;
        set_bits = '0;
        if (core_q.phase == PH_IDLE) begin
            core_d.ser  = 1'b1;
            core_d.busy = 1'b0;
            if ((is_tx && start) ||
                (is_rx && (async_mode ? (bit_tick && !rx_bit) : start))) begin
                core_d.busy  = 1'b1;
                core_d.txm   = is_tx;
                core_d.dp    = is_tx;
                core_d.sof   = is_tx && async_mode;
                core_d.bcnt  = '0;
                core_d.sh    = '0;
                core_d.left  = fixed_cnt;
                core_d.phase = var_len ? PH_SIZE : PH_DATA;
            end
        end else begin
            if (core_q.txm && core_q.dp) begin
                if (core_q.phase == PH_SIZE) begin
                    core_d.sh   = CHKF_W'(size_enc);
                    core_d.left = LEFT_W'(tx_byte[CNT_W-1:0]) + LEFT_W'(1);
                end else begin
                    core_d.sh = CHKF_W'(tx_byte);
                end
            end
            if (bit_tick && core_q.txm) begin
                if (core_q.sof) begin
                    core_d.ser = 1'b0;
                    core_d.sof = 1'b0;
                end else if (core_q.phase == PH_END) begin
                    core_d.ser   = 1'b1;
                    core_d.busy  = 1'b0;
                    core_d.phase = PH_IDLE;
                end else begin
                    core_d.ser  = core_q.sh[0];
                    core_d.sh   = core_q.sh >> 1;
                    core_d.bcnt = core_q.bcnt + BCNT_W'(1);
                    if (core_q.phase == PH_CHK) begin
                        if (core_q.bcnt == chk_last) core_d.phase = PH_END;
                    end else if (core_q.bcnt == BYTE_LAST) begin
                        core_d.bcnt = '0;
                        if (core_q.phase == PH_SIZE) begin
                            core_d.phase = PH_DATA;
                            core_d.dp    = 1'b1;
                        end else if (core_q.left == LEFT_W'(1)) begin
                            core_d.phase = PH_CHK;
                            core_d.sh    = chk_tx & chk_mask;
                        end else begin
                            core_d.left = core_q.left - LEFT_W'(1);
                            core_d.dp   = 1'b1;
                        end
                    end
                end
            end else if (bit_tick) begin
                if (async_mode && rx_bit_bad) set_bits[0] = 1'b1;
                core_d.bcnt = core_q.bcnt + BCNT_W'(1);
                if (core_q.phase == PH_CHK) begin
                    core_d.sh = chk_full;
                    if (core_q.bcnt == chk_last) begin
                        if (chk_got != (chk_rx & chk_mask)) set_bits[1] = 1'b1;
                        core_d.phase = PH_IDLE;
                        core_d.busy  = 1'b0;
                    end
                end else begin
                    core_d.sh = CHKF_W'(rx_byte);
                    if (core_q.bcnt == BYTE_LAST) begin
                        core_d.bcnt = '0;
                        if (core_q.phase == PH_SIZE) begin
                            if (!size_ok) set_bits[2] = 1'b1;
                            core_d.left  = LEFT_W'(rx_cnt) + LEFT_W'(1);
                            core_d.phase = PH_DATA;
                        end else begin
                            core_d.rxd = rx_byte;
                            core_d.dp  = 1'b1;
                            if (core_q.left == LEFT_W'(1)) begin
                                core_d.phase = PH_CHK;
                                core_d.sh    = '0;
                            end else begin
                                core_d.left = core_q.left - LEFT_W'(1);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= CORE_RST;
        else     core_q <= core_d;
    end

    assign data_pulse = core_q.dp;
    assign busy       = core_q.busy;
    assign ser_out    = core_q.ser;
    assign bus_out    = (is_tx || is_rx) ? core_q.rxd
                                         : {{(DATA_W-STAT_W){1'b0}}, status};

    // R6
    dp_single_chk: assert property (@(posedge clk) disable iff (rst)
        data_pulse |=> !data_pulse);
    // R6
    dp_in_msg_chk: assert property (@(posedge clk) disable iff (rst)
        data_pulse |-> busy);
    // R4
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ser_out);
    // R7
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(start) || $past(bit_tick)));
    // R11
    stat_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !is_tx && !is_rx) |=> !busy);
endmodule

// File: tb/sim_msg_framer.sv
module sim_msg_framer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_sel = 2'b00;
    logic        async_mode = 1'b0;
    logic [1:0]  len_code = 2'b01;
    logic        long_chk = 1'b0;
    logic        start = 1'b0;
    logic        bit_tick = 1'b0;
    logic        rx_bit = 1'b1;
    logic        rx_bit_bad = 1'b0;
    logic [7:0]  tx_byte = 8'h00;
    logic [14:0] chk_tx = '0;
    logic [14:0] chk_rx = '0;
    logic [7:0]  bus_out;
    logic        data_pulse, busy, err, ser_out;

    msg_framer u0 (
        .clk(clk), .rst(rst), .op_sel(op_sel), .async_mode(async_mode),
        .len_code(len_code), .long_chk(long_chk), .start(start),
        .bit_tick(bit_tick), .rx_bit(rx_bit), .rx_bit_bad(rx_bit_bad),
        .tx_byte(tx_byte), .chk_tx(chk_tx), .chk_rx(chk_rx),
        .bus_out(bus_out), .data_pulse(data_pulse), .busy(busy),
        .err(err), .ser_out(ser_out)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic       exp_bits [0:255];
    int         exp_len;
    logic [7:0] dbytes [0:7];
    logic [2:0] exp_status;
    int         seg_sof, seg_size, seg_data, seg_chk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] size_enc(input logic [2:0] n);
        return {^n, n, ^n, n};
    endfunction

    function automatic int nbytes(input logic [1:0] code, input logic [2:0] n);
        return (code == 2'b00) ? int'(n) + 1 : 2 * int'(code);
    endfunction

    task automatic push(input logic b);
        exp_bits[exp_len] = b;
        exp_len++;
    endtask

    task automatic build_frame(input bit as, input logic [1:0] code, input bit h,
                               input logic [2:0] n, input logic [14:0] chk);
        int nb;
        logic [7:0] sz;
        nb = nbytes(code, n);
        exp_len = 0;
        for (int i = 0; i < 8; i++) dbytes[i] = 8'($urandom);
        if (as) push(1'b0);
        seg_sof = exp_len;
        sz = size_enc(n);
        if (code == 2'b00) for (int i = 0; i < 8; i++) push(sz[i]);
        seg_size = exp_len;
        for (int k = 0; k < nb; k++) for (int i = 0; i < 8; i++) push(dbytes[k][i]);
        seg_data = exp_len;
        for (int i = 0; i < (h ? 15 : 7); i++) push(chk[i]);
        seg_chk = exp_len;
    endtask

    task automatic run_tx(input bit as, input logic [1:0] code, input bit h,
                          input logic [2:0] n, input logic [14:0] chk);
        int got, dpc, widx, nw, b_sof, b_size, b_data, b_chk, b_end;
        bit pend, prev_tick, prev_busy;
        logic [7:0] words [0:8];
        build_frame(as, code, h, n, chk);
        push(1'b1);
        nw = 0;
        if (code == 2'b00) begin words[0] = {5'($urandom), n}; nw = 1; end
        for (int k = 0; k < nbytes(code, n); k++) begin words[nw] = dbytes[k]; nw++; end
        got = 0; dpc = 0; widx = 0; pend = 0;
        b_sof = 0; b_size = 0; b_data = 0; b_chk = 0; b_end = 0;
        @(negedge clk);
        op_sel = 2'b10; async_mode = as; len_code = code; long_chk = h;
        chk_tx = chk; tx_byte = words[0]; start = 1'b1; bit_tick = 1'b0;
        prev_tick = 1'b0; prev_busy = 1'b0;
        for (int i = 1; i < 1000; i++) begin
            @(negedge clk);
            if (prev_tick && prev_busy) begin
                if (got < exp_len && ser_out !== exp_bits[got]) begin
                    if (got < seg_sof) b_sof++;
                    else if (got < seg_size) b_size++;
                    else if (got < seg_data) b_data++;
                    else if (got < seg_chk) b_chk++;
                    else b_end++;
                end
                got++;
            end
            if (pend) begin
                widx++;
                tx_byte = (widx < nw) ? words[widx] : 8'h00;
                pend = 1'b0;
            end
            if (data_pulse) begin dpc++; pend = 1'b1; end
            // R7: busy rises one cycle after start
            if (i == 1) check(busy === 1'b1, "R7", "tx busy after start", busy, 1);
            if (i > 1 && !busy) break;
            start = 1'b0;
            bit_tick = (i % 4 == 2);
            prev_tick = bit_tick;
            prev_busy = busy;
        end
        bit_tick = 1'b0;
        check(b_sof == 0, "R4", "start bit mismatches", b_sof, 0);
        check(b_size == 0, "R3", "size byte mismatches", b_size, 0);
        check(b_data == 0, "R2", "data bit mismatches", b_data, 0);
        check(b_chk == 0, "R5", "check field mismatches", b_chk, 0);
        check(b_end == 0, "R4", "final idle bit", b_end, 0);
        check(got == exp_len, "R7", "bits while busy", got, exp_len);
        check(dpc == nw, "R6", "tx data pulses", dpc, nw);
        check(ser_out === 1'b1, "R4", "line idle after message", ser_out, 1);
    endtask

    task automatic run_rx(input bit as, input logic [1:0] code, input bit h,
                          input logic [2:0] n, input logic [14:0] chk_sent,
                          input logic [14:0] chk_exp, input int bad_sz, input int bad_tk);
        int rcv, nb, k, pre, last_i;
        logic [14:0] m;
        build_frame(as, code, h, n, chk_sent);
        nb = nbytes(code, n);
        if (bad_sz >= 0) exp_bits[seg_sof + bad_sz] = ~exp_bits[seg_sof + bad_sz];
        m = h ? 15'h7fff : 15'h007f;
        if (bad_sz >= 0) exp_status[2] = 1'b1;
        if ((chk_sent & m) != (chk_exp & m)) exp_status[1] = 1'b1;
        if (as && bad_tk >= 0) exp_status[0] = 1'b1;
        rcv = 0; k = 0; pre = as ? 2 : 0; last_i = -1;
        @(negedge clk);
        op_sel = 2'b01; async_mode = as; len_code = code; long_chk = h;
        chk_rx = chk_exp; rx_bit = 1'b1; rx_bit_bad = 1'b0; bit_tick = 1'b0;
        start = !as;
        for (int i = 1; i < 1200; i++) begin
            @(negedge clk);
            if (data_pulse) begin
                // R6: byte shown with the pulse
                check(rcv < nb && bus_out === dbytes[rcv], "R6", "rx byte", bus_out,
                      (rcv < nb) ? dbytes[rcv] : 8'hxx);
                rcv++;
            end
            start = 1'b0;
            if (last_i >= 0 && i > last_i + 3) break;
            if (i % 4 == 2 && k < exp_len + pre) begin
                bit_tick = 1'b1;
                if (k < pre) begin
                    rx_bit = 1'b1; rx_bit_bad = 1'b0;
                end else begin
                    rx_bit = exp_bits[k - pre];
                    rx_bit_bad = ((k - pre) == bad_tk);
                end
                k++;
                if (k == exp_len + pre) last_i = i;
            end else begin
                bit_tick = 1'b0; rx_bit = 1'b1; rx_bit_bad = 1'b0;
            end
        end
        bit_tick = 1'b0;
        check(rcv == nb, "R2", "rx byte count", rcv, nb);
        check(busy === 1'b0, "R7", "rx busy after message", busy, 0);
        @(negedge clk);
        op_sel = 2'b00;
        #1;
        check(bus_out === {5'b0, exp_status}, (bad_sz >= 0) ? "R8" : "R9",
              "status read", bus_out, {5'b0, exp_status});
        check(err === |exp_status, "R11", "err output", err, |exp_status);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; start = 1'b0; bit_tick = 1'b0; op_sel = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_status = '0;
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4242);
        exp_status = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        check(busy === 1'b0, "R1", "busy at reset", busy, 0);
        check(ser_out === 1'b1, "R1", "ser_out at reset", ser_out, 1);
        check(data_pulse === 1'b0, "R1", "data_pulse at reset", data_pulse, 0);
        check(err === 1'b0, "R1", "err at reset", err, 0);
        check(bus_out === 8'h00, "R1", "status at reset", bus_out, 0);

        // R11: start ignored in status mode
        @(negedge clk); op_sel = 2'b00; start = 1'b1;
        repeat (6) @(negedge clk);
        check(busy === 1'b0, "R11", "start in status mode", busy, 0);
        start = 1'b0;

        // R2 R4 R5: directed transmit frames
        run_tx(1'b0, 2'b01, 1'b0, 3'd0, 15'h2a5b);
        run_tx(1'b1, 2'b00, 1'b1, 3'd0, 15'h5a3c);  // R3 one byte
        run_tx(1'b1, 2'b00, 1'b0, 3'd7, 15'h0071);  // R3 eight bytes
        run_tx(1'b0, 2'b11, 1'b1, 3'd0, 15'h7fff);
        run_tx(1'b0, 2'b00, 1'b0, 3'd5, 15'h0000);

        // R12 async start, clean
        run_rx(1'b1, 2'b00, 1'b0, 3'd3, 15'h0055, 15'h0055, -1, -1);
        // R9 check mismatch in sync mode, then R11 sticky over clean message
        run_rx(1'b0, 2'b10, 1'b1, 3'd0, 15'h1234, 15'h1235, -1, -1);
        run_rx(1'b0, 2'b01, 1'b0, 3'd0, 15'h0011, 15'h0011, -1, -1);
        do_reset();
        // R8 corrupt upper parity bit
        run_rx(1'b1, 2'b00, 1'b1, 3'd6, 15'h4321, 15'h4321, 7, -1);
        do_reset();
        // R10 bad bit ignored in sync, counted in async
        run_rx(1'b0, 2'b01, 1'b0, 3'd0, 15'h0003, 15'h0003, -1, 5);
        run_rx(1'b1, 2'b11, 1'b0, 3'd0, 15'h0003, 15'h0003, -1, 9);
        do_reset();

        for (int r = 0; r < 24; r++) begin
            bit as, h;
            logic [1:0] code;
            logic [2:0] n;
            logic [14:0] c;
            as = 1'($urandom); h = 1'($urandom);
            code = 2'($urandom); n = 3'($urandom); c = 15'($urandom);
            if (r % 2 == 0) run_tx(as, code, h, n, c);
            else begin
                int bsz, btk;
                logic [14:0] ce;
                bsz = (code == 2'b00 && ($urandom % 3 == 0)) ? 3 + int'($urandom % 5) : -1;
                btk = ($urandom % 3 == 0) ? 1 + int'($urandom % 8) : -1;
                ce = ($urandom % 3 == 0) ? c ^ 15'h0001 : c;
                run_rx(as, code, h, n, c, ce, bsz, btk);
                do_reset();
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule